// File: doc/BRIEF.md
# Variable-Latency Word Memory

This block is a word-addressed storage array that serves a single read or write request at a time. It does not answer within a fixed cycle. After it accepts a request it raises a busy flag. It keeps that flag high for a configurable number of cycles, then lowers it. At that point the read data is on the output or the write has been committed. A processor control sequence uses it for fetch, load and store. The sequence issues a strobe and then waits for busy to fall before it samples the output or moves on.

A request is accepted on a rising clock edge when the strobe is high and the block is idle. On that edge the block captures the address, the write data and the direction. Input changes after that edge have no effect on the request in flight. Strobes that arrive while busy is high are dropped without trace. The output register always carries a defined value, and it changes only at the completion of a read.

Top module: `slow_word_mem`

## Requirements
- R1: While reset is asserted and after its release, `busy_o` is 0 and `rdata_o` is all zeros. Every storage word is cleared to zero by reset.
- R2: A strobe (`req_i`=1) seen at a rising edge while `busy_o`=0 is accepted, and `busy_o` is 1 from that edge on.
- R3: After acceptance, `busy_o` stays high for exactly `LATENCY` clock cycles and then returns to 0 (`LATENCY` >= 2).
- R4: For a read (`wr_i`=0), when `busy_o` falls, `rdata_o` equals the word stored at the captured address.
- R5: For a write (`wr_i`=1), the captured data is stored at the captured address by the time `busy_o` falls, and a later read of that address returns it.
- R6: A strobe while `busy_o`=1 is ignored. It changes no stored word and does not alter when the current request completes.
- R7: Address, data and direction are taken on the accepting edge. Later changes on `addr_i`, `wdata_i` and `wr_i` do not affect the request in progress.
- R8: `rdata_o` changes only on the edge where a read completes. It holds its value while busy, while idle, and across completed writes.
- R9: Each word address selects an independent word. Address 0 and the highest address, `2**ADDR_W-1`, are both usable and do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | Direction: 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data register |
| busy_o | output | 1 | High while a request is in progress |

## Verification
A wrong latency count shows up as a busy pulse that is too short or too long on the very first request. The bench counts the cycles of that pulse directly. If the captured request were not held, or a strobe during busy were let through, the wrong word would land in storage. That damage only becomes visible on a later read of the affected address, so the bench reads back both the intended and the disturbed address right away. A read-data register that updated at the wrong moment would change `rdata_o` while busy or after a write. Sampling in every busy cycle catches this within one clock.

// File: rtl/slow_mem_pkg.sv
package slow_mem_pkg;

   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

endpackage

// File: rtl/mem_lat_timer.sv
module mem_lat_timer
   import slow_mem_pkg::*;
#(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(LATENCY - 1);

   tmr_state_e    state_q;
   logic [CW-1:0] cnt_q;

   assign busy_o = (state_q == TMR_RUN);
   assign done_o = busy_o && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TMR_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            TMR_IDLE: begin
               if (start_i) begin
                  state_q <= TMR_RUN;
                  cnt_q   <= LOAD_VAL;
               end
            end
            TMR_RUN: begin
               if (cnt_q == '0) begin
                  state_q <= TMR_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= TMR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mem_req_latch.sv
module mem_req_latch #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_o    <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
      end else if (load_i) begin
         wr_o    <= wr_i;
         addr_o  <= addr_i;
         wdata_o <= wdata_i;
      end
   end
endmodule

// File: rtl/mem_word_array.sv
module mem_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[gi] <= '0;
         end else if (we_i && (addr_i == ADDR_W'(gi))) begin
            words[gi] <= wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (re_i) begin
         rdata_o <= words[addr_i];
      end
   end
endmodule

// File: rtl/slow_word_mem.sv
module slow_word_mem #(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter int LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o
);
   if (LATENCY < 2) begin : g_bad_latency
      $error("slow_word_mem: LATENCY must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("slow_word_mem: ADDR_W out of range 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("slow_word_mem: DATA_W must be positive");
   end

   logic              accept;
   logic              done;
   logic              cap_wr;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_wdata;

   assign accept = req_i && !busy_o;

   mem_lat_timer #(.LATENCY(LATENCY)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .busy_o  (busy_o),
      .done_o  (done)
   );

   mem_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .wr_o    (cap_wr),
      .addr_o  (cap_addr),
      .wdata_o (cap_wdata)
   );

   mem_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (done && cap_wr),
      .re_i    (done && !cap_wr),
      .addr_i  (cap_addr),
      .wdata_i (cap_wdata),
      .rdata_o (rdata_o)
   );
endmodule

// File: rtl/slow_word_mem_chk.sv
module slow_word_mem_chk #(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              busy_o,
   input logic [DATA_W-1:0] rdata_o
);
   localparam int CW = $clog2(LATENCY + 2);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && rdata_o == '0));

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !busy_o) |=> busy_o);

   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && run_cnt < CW'(LATENCY - 1)) |=> busy_o);

   assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_cnt == CW'(LATENCY)));

   assert_rdata_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_o) |-> $fell(busy_o));
endmodule

bind slow_word_mem slow_word_mem_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (.*);

// File: tb/slow_word_mem_tb.sv
module slow_word_mem_tb;
   localparam int AW  = 6;
   localparam int DW  = 32;
   localparam int LAT = 4;
   localparam int TOP = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;
   int wd = 0;
   logic [DW-1:0] model [1 << AW];

   always #10 clk = ~clk;

   slow_word_mem #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Issue one request, disturb inputs during busy, verify busy length and rdata hold.
   task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic poke, input logic [AW-1:0] pa, input logic [DW-1:0] pd);
      int len;
      logic [DW-1:0] held;
      held = rdata;
      @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      check("R2 busy after accept", {31'd0, busy}, 32'd1);
      wr = ~w; addr = ~a; wdata = ~d;  // R7: inputs move after acceptance
      len = 0;
      while (busy && len < 50) begin
         if (rdata !== held) check("R8 rdata held while busy", rdata, held);
         if (poke && len == 1) begin
            req = 1'b1; wr = 1'b1; addr = pa; wdata = pd;  // R6: strobe while busy
         end else begin
            req = 1'b0;
         end
         len++;
         @(negedge clk);
      end
      req = 1'b0;
      check("R3 busy length", len, LAT);
      if (w) begin
         model[a] = d;
         check("R8 rdata unchanged by write", rdata, held);
      end else begin
         check("R4 read result", rdata, model[a]);
      end
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      access(1'b0, a, '0, 1'b0, '0, '0);
      check(tag, rdata, model[a]);
   endtask

   task automatic t_reset();
      check("R1 busy in reset", {31'd0, busy}, 32'd0);
      check("R1 rdata in reset", rdata, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", {31'd0, busy}, 32'd0);
      check("R1 rdata after reset", rdata, 32'd0);
      rd("R1 unwritten word is zero", 6'd17);
   endtask

   task automatic t_write_read();
      access(1'b1, 6'd5, 32'hDEAD_BEEF, 1'b0, '0, '0);
      rd("R5 write then read", 6'd5);
      access(1'b1, 6'd6, 32'h0000_0001, 1'b0, '0, '0);
      access(1'b1, 6'd7, 32'hFFFF_FFFF, 1'b0, '0, '0);
      rd("R5 pattern ones", 6'd7);
      rd("R5 pattern one", 6'd6);
      rd("R5 first word kept", 6'd5);
   endtask

   task automatic t_bounds();
      access(1'b1, 6'd0, 32'h1234_5678, 1'b0, '0, '0);
      access(1'b1, 6'(TOP), 32'hA5A5_5A5A, 1'b0, '0, '0);
      rd("R9 address zero", 6'd0);
      rd("R9 highest address", 6'(TOP));
      rd("R9 neighbour untouched", 6'd1);
   endtask

   task automatic t_ignore();
      access(1'b1, 6'd20, 32'hCAFE_0020, 1'b1, 6'd21, 32'hBAD0_0021);
      rd("R6 ignored strobe left word 21", 6'd21);
      rd("R6 real write landed", 6'd20);
      access(1'b0, 6'd20, '0, 1'b1, 6'd22, 32'hBAD0_0022);
      rd("R6 read with strobe kept word 22", 6'd22);
   endtask

   task automatic t_capture();
      // access() already inverts the inputs during busy; verify the inverted address untouched
      access(1'b1, 6'd9, 32'h0BAD_F00D, 1'b0, '0, '0);
      rd("R7 captured address", 6'd9);
      rd("R7 moved address untouched", ~6'd9);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected < 100000 cycles", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      t_reset();
      t_write_read();
      t_bounds();
      t_ignore();
      t_capture();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule